// File: doc/BRIEF.md
# Host Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from up to eighteen device-side sources into sticky status bits. A per-bit mask gates those bits onto one active-high interrupt line toward the host. Each status bit stays set until the host clears it, so an event is never lost while its source is masked. Once the bit is unmasked, the pending event drives the line.

The host uses a small register bus: a word address, a write strobe with write data, and a read strobe. Read data comes back registered. The host can change the mask in three ways: a plain write, a write-one-to-set alias, or a write-one-to-clear alias. The status array is visible through two views. One view can be read with no side effect. The other clears every bit in the same access that returns it. A write-one-to-acknowledge register clears chosen status bits.

Top module: `host_irq_ctrl`

## Requirements
- R1: During and after reset, the mask holds 0x00001 (only source 0 masked), all status bits are 0, irq_o is 0 and rdata_o is 0.
- R2: A write to address 0 loads the mask from wdata_i. A read of address 0 returns the mask. Only source positions 0 to 10, 14, 16 and 17 exist; every other bit of every register reads 0.
- R3: A write to address 1 sets each mask bit written as 1 and leaves the others unchanged.
- R4: A write to address 2 clears each mask bit written as 1 and leaves the others unchanged.
- R5: A status bit is set after any cycle in which its source input is high, whether or not the bit is masked. Inputs at unused positions never set anything.
- R6: A read of address 3 returns the status bits and leaves them unchanged.
- R7: A read of address 4 returns the status bits and clears all of them at the same clock edge.
- R8: A write to address 5 clears each status bit written as 1, and both status views then read it as 0. Bits written as 0 are unaffected.
- R9: If a source is high in the same cycle that its bit is cleared by a read of address 4 or by a write to address 5, the bit stays set.
- R10: irq_o is registered. After each clock edge it equals the OR over all bits of (status AND NOT mask), taken from the register values held before that edge.
- R11: Addresses 1, 2 and 5 read as 0. Addresses 6 and 7 read as 0, and writes to them have no effect. Writes to addresses 3 and 4 change nothing.
- R12: rdata_o is loaded at the clock edge that samples re_i high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| src_i | input | 18 | Event inputs, one per source position |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The properties assume that the inputs are stable at each rising edge. They also assume that any source position can pulse in any cycle, including the cycle in which its bit is being cleared. For that reason, the acknowledge and peek properties only constrain the bits whose source is quiet in that cycle. The stimulus drives every input half a period away from the sampling edge. It mixes directed sequences with random traffic over all eight addresses, including unused ones, and it raises events on reserved source positions as well as used ones.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_MSET = 3'd1,
    SEL_MCLR = 3'd2,
    SEL_PEEK = 3'd3,
    SEL_POP  = 3'd4,
    SEL_ACK  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic ack_wr;
    logic pop_rd;
  } strobe_t;
endpackage

// File: rtl/hirq_decode.sv
module hirq_decode
  import hirq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  output strobe_t           stb_o
);
  always_comb begin
    stb_o          = '0;
    stb_o.mask_wr  = we_i && (addr_i == SEL_MASK);
    stb_o.mask_set = we_i && (addr_i == SEL_MSET);
    stb_o.mask_clr = we_i && (addr_i == SEL_MCLR);
    stb_o.ack_wr   = we_i && (addr_i == SEL_ACK);
    stb_o.pop_rd   = re_i && (addr_i == SEL_POP);
  end
endmodule

// File: rtl/hirq_mask_reg.sv
module hirq_mask_reg #(
  parameter int unsigned          NSRC      = 18,
  parameter logic [NSRC-1:0]      USED_MASK = 18'h347FF,
  parameter logic [NSRC-1:0]      MASK_RST  = 18'h00001
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [NSRC-1:0] wbits_i,
  output logic [NSRC-1:0] mask_o
);
  logic [NSRC-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (load_i)     mask_d = wbits_i;
    else if (set_i) mask_d = mask_q | wbits_i;
    else if (clr_i) mask_d = mask_q & ~wbits_i;
    mask_d = mask_d & USED_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RST & USED_MASK;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/hirq_status_reg.sv
module hirq_status_reg #(
  parameter int unsigned     NSRC      = 18,
  parameter logic [NSRC-1:0] USED_MASK = 18'h347FF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);
  logic [NSRC-1:0] stat_q;

  // set dominates clear per bit
  for (genvar b = 0; b < NSRC; b++) begin : g_bit
    if (USED_MASK[b]) begin : g_used
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stat_q[b] <= 1'b0;
        else if (evt_i[b]) stat_q[b] <= 1'b1;
        else if (clr_i[b]) stat_q[b] <= 1'b0;
      end
    end else begin : g_rsvd
      assign stat_q[b] = 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/hirq_read_port.sv
module hirq_read_port
  import hirq_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NSRC = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   mask_i,
  input  logic [NSRC-1:0]   stat_i,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0]   rdata_q;
  logic [NSRC-1:0] sel_bits;

  always_comb begin
    unique case (addr_i)
      SEL_MASK:          sel_bits = mask_i;
      SEL_PEEK, SEL_POP: sel_bits = stat_i;
      default:           sel_bits = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= DW'(sel_bits);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hirq_pkg::*;
#(
  parameter int unsigned     DW        = 32,
  parameter int unsigned     NSRC      = 18,
  parameter logic [NSRC-1:0] USED_MASK = 18'h347FF,
  parameter logic [NSRC-1:0] MASK_RST  = 18'h00001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NSRC-1:0]   src_i,
  output logic              irq_o
);
  localparam logic [NSRC-1:0] ALL_ONES = '1;

  strobe_t         stb;
  logic [NSRC-1:0] wbits, mask_q, stat_q, evt, clr;
  logic            irq_q;

  assign wbits = wdata_i[NSRC-1:0] & USED_MASK;
  assign evt   = src_i & USED_MASK;
  assign clr   = (stb.ack_wr ? wbits : '0) | (stb.pop_rd ? ALL_ONES : '0);

  hirq_decode u_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .re_i   (re_i),
    .stb_o  (stb)
  );

  hirq_mask_reg #(.NSRC(NSRC), .USED_MASK(USED_MASK), .MASK_RST(MASK_RST)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (stb.mask_wr),
    .set_i   (stb.mask_set),
    .clr_i   (stb.mask_clr),
    .wbits_i (wbits),
    .mask_o  (mask_q)
  );

  hirq_status_reg #(.NSRC(NSRC), .USED_MASK(USED_MASK)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .stat_o (stat_q)
  );

  hirq_read_port #(.DW(DW), .NSRC(NSRC)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (re_i),
    .addr_i  (addr_i),
    .mask_i  (mask_q),
    .stat_i  (stat_q),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_q & ~mask_q);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk
  import hirq_pkg::*;
#(
  parameter int unsigned     DW        = 32,
  parameter int unsigned     NSRC      = 18,
  parameter logic [NSRC-1:0] USED_MASK = 18'h347FF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DW-1:0]     wdata_i,
  input logic              re_i,
  input logic [NSRC-1:0]   src_i,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   stat_q,
  input logic              irq_o
);
  a_r3_set_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_MSET) |=>
      ((mask_q & $past(wdata_i[NSRC-1:0] & USED_MASK)) == $past(wdata_i[NSRC-1:0] & USED_MASK)));

  a_r4_clr_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_MCLR) |=> ((mask_q & $past(wdata_i[NSRC-1:0])) == '0));

  a_r5_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i != '0) |=> ((stat_q & $past(src_i & USED_MASK)) == $past(src_i & USED_MASK)));

  a_r6_peek_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !we_i && addr_i == SEL_PEEK && src_i == '0) |=> $stable(stat_q));

  a_r7_pop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == SEL_POP) |=> ((stat_q & ~$past(src_i)) == '0));

  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SEL_ACK) |=>
      ((stat_q & $past(wdata_i[NSRC-1:0]) & ~$past(src_i)) == '0));

  a_r10_irq_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(stat_q & ~mask_q))));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q | mask_q) & ~USED_MASK) == '0);
endmodule

bind host_irq_ctrl hirq_chk #(.DW(DW), .NSRC(NSRC), .USED_MASK(USED_MASK)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .src_i   (src_i),
  .mask_q  (mask_q),
  .stat_q  (stat_q),
  .irq_o   (irq_o)
);

// File: tb/sim_host_irq_ctrl.sv
module sim_host_irq_ctrl;
  localparam int DW = 32;
  localparam int NS = 18;
  localparam logic [NS-1:0] USED = 18'h347FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NS-1:0] src = '0;
  logic          irq;

  int checks = 0, fails = 0, cyc = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  host_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  // behavioural reference
  bit [NS-1:0] m_mask, m_stat;
  bit [DW-1:0] m_rdata;
  bit          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 18'h00001; m_stat = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      bit [NS-1:0] wipe, nm;
      bit [DW-1:0] view;
      wipe = '0;
      nm = m_mask;
      m_irq = ((m_stat & ~m_mask) != 0);
      if (re) begin
        view = '0;
        if (addr == 0) view = {14'b0, m_mask};
        if (addr == 3 || addr == 4) view = {14'b0, m_stat};
        m_rdata = view;
        if (addr == 4) wipe = '1;
      end
      if (we) begin
        if (addr == 0) nm = wdata[NS-1:0];
        if (addr == 1) nm = m_mask | wdata[NS-1:0];
        if (addr == 2) nm = m_mask & ~wdata[NS-1:0];
        if (addr == 5) wipe = wipe | wdata[NS-1:0];
      end
      m_mask = nm & USED;
      m_stat = ((m_stat & ~wipe) | src) & USED;
    end
  end

  task automatic compare();
    checks += 2;
    if (rdata !== m_rdata) begin
      fails++;
      $display("FAIL %s rdata cyc=%0d actual=%h expected=%h", req, cyc, rdata, m_rdata);
    end
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq cyc=%0d actual=%b expected=%b", req, cyc, irq, m_irq);
    end
  endtask

  task automatic tick(input bit w, input bit [2:0] a, input bit [DW-1:0] d,
                      input bit r, input bit [NS-1:0] s);
    @(negedge clk);
    compare();
    we = w; addr = a; wdata = d; re = r; src = s;
  endtask

  task automatic wr(input bit [2:0] a, input bit [DW-1:0] d); tick(1, a, d, 0, '0); endtask
  task automatic rd(input bit [2:0] a); tick(0, a, '0, 1, '0); endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, '0, 0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2); rd(0); idle(2); rd(3); idle(1);

    req = "R2";
    wr(0, 32'hFFFF_FFFF); rd(0); idle(1);
    wr(0, 32'h0000_1234); rd(0); idle(1);

    req = "R3";
    wr(1, 32'h0003_0001); rd(0); idle(1);
    req = "R4";
    wr(2, 32'h0000_0234); rd(0); idle(1);
    wr(0, 32'h0); idle(1);

    req = "R5";
    tick(0, 0, '0, 0, 18'h3FFFF); idle(2); rd(3); idle(1);
    req = "R6";
    rd(3); rd(3); idle(1);
    req = "R7";
    rd(4); rd(3); idle(2);

    req = "R5";
    wr(0, 32'h0000_0080);
    tick(0, 0, '0, 0, 18'h00080); idle(3); rd(3);
    req = "R10";
    wr(2, 32'h0000_0080); idle(3);
    req = "R8";
    tick(1, 5, 32'h0000_0080, 0, 18'h00400); idle(1); rd(3); rd(4); idle(2);

    req = "R9";
    tick(0, 0, '0, 0, 18'h04001); idle(1);
    tick(1, 5, 32'h0000_4001, 0, 18'h00001); rd(3); idle(1);
    tick(0, 4, '0, 1, 18'h10000); rd(3); idle(1); rd(4); idle(1);

    req = "R11";
    tick(0, 0, '0, 0, 18'h00003);
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    rd(3); rd(0); rd(1); rd(2); rd(5); rd(6); rd(7); idle(1); rd(4);

    req = "R12";
    rd(0); idle(4); wr(0, 32'h5); idle(2); rd(0); idle(2);

    req = "R10";
    for (int i = 0; i < 600; i++) begin
      bit [2:0] a;
      a = 3'($urandom_range(0, 7));
      tick(($urandom % 3) == 0, a, $urandom, ($urandom % 3) == 0,
           NS'($urandom & $urandom & $urandom));
    end
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule